// File: doc/BRIEF.md
# Eight-Channel DAC Code Register Controller

This block is the digital register core for an eight-channel 12-bit converter. It takes writes that have already been deserialised: a 4-bit address, a 12-bit data word and a one-cycle write strobe. Each channel has an input code register. Each channel also has an output code register, which feeds the converter through the `dac_code` bus. A level-sensitive active-low load pin lets the input codes pass to the output registers. An asynchronous active-low preset pin replaces every output code with a common preset value.

Two control registers set the chip-wide options: full power-down, data-out enable, reference source, internal reference level and input number format. They also set a power-down flag and a speed flag for each pair of channels. A second write path, the pair addresses, drives two channels at once with complementary codes. When signed input is selected, each incoming channel code is turned into an offset-binary code before it is stored.

Top module: `dac_regbank_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every channel code, every power-down output, every speed output, `dout_en`, `ref_internal` and `ref_high` read 0.
- R2: A write to address 0..7 stores the data in the input register of channel 0..7. While `load_n` is high, `dac_code` does not change.
- R3: While `load_n` is low, each output register copies its input register on every clock edge. With `load_n` held low, a value written on clock edge k appears on `dac_code` after edge k+1. Channel i occupies `dac_code[12*i +: 12]`.
- R4: A write to address 8 sets the global control register. Bit 4 is full power-down, bit 3 drives `dout_en`, bit 2 drives `ref_internal` (1 = internal), bit 1 drives `ref_high` (1 = the higher level) and bit 0 selects signed input. Each output changes on the write edge.
- R5: A write to address 9 sets the pair control register. Bits 7,6,5,4 are the power-down flags and bits 3,2,1,0 are the speed flags, each group ordered as pairs GH, EF, CD, AB. `ch_pd[i]` is the power-down flag of pair i/2. `pair_fast[p]` is the speed flag of pair p, with p = 0 for AB, and 1 means fast.
- R6: While full power-down is set, all eight `ch_pd` bits are 1 whatever the pair flags hold. The pair flags are kept and reappear when full power-down is cleared.
- R7: Address 10 holds the preset value. Two clock edges after `preset_n` goes low, every channel code equals the preset value. Two edges after `preset_n` goes high, the held output registers show again.
- R8: If address 10 has not been written since reset, an asserted preset drives every channel code to 0.
- R9: A write to address 12+p (p = 0..3) stores the data in channel 2p and its bitwise complement in channel 2p+1.
- R10: With signed input selected, the MSB of data written to addresses 0..7 and 12..15 is inverted before storage. For pair writes this inversion happens before the complement is formed. The preset value is stored as written.
- R11: A write to address 11 changes no register.
- R12: Asserting reset at any time clears the input, output, control and preset registers and the preset-written state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Write data |
| load_n | input | 1 | Level-sensitive load, active low |
| preset_n | input | 1 | Asynchronous preset, active low |
| dac_code | output | 96 | Eight channel codes, channel i in bits 12*i+11..12*i |
| ch_pd | output | 8 | Per-channel power-down |
| pair_fast | output | 4 | Per-pair speed, 1 = fast, index 0 = AB |
| ref_internal | output | 1 | Internal reference selected |
| ref_high | output | 1 | Higher internal reference level selected |
| dout_en | output | 1 | Data-out enable |

## Verification
The assertions check several rules on every cycle. The output registers copy the input registers while load is low and hold while it is high. A synchronised preset makes every code equal the preset value. Full power-down forces every channel power-down bit. A pair write leaves the two channels complementary, and an address-11 write leaves all state stable. The bench scenarios cover the rest. These are the bit positions of both control registers, the fixed latency of the load and preset paths, the zero preset after reset, the signed-input conversion in single and pair writes, and a reset in the middle of operation.

// File: rtl/dacrb_pkg.sv
package dacrb_pkg;
  localparam int CODE_W = 12;
  localparam int N_CH   = 8;
  localparam int N_PAIR = N_CH / 2;
  localparam int ADDR_W = 4;

  localparam int A_CTRL0  = 8;
  localparam int A_CTRL1  = 9;
  localparam int A_PRESET = 10;
  localparam int A_PAIR0  = 12;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic full_pd;
    logic dout_en;
    logic ref_int;
    logic ref_hi;
    logic twos;
  } ctrl0_t;

  // Signed input becomes offset binary by flipping the sign bit.
  function automatic code_t fmt_code(code_t d, logic twos);
    code_t msb;
    msb = code_t'(1) << (CODE_W - 1);
    return twos ? (d ^ msb) : d;
  endfunction

  // Second channel of a pair receives the complement.
  function automatic code_t pair_code(code_t d, logic second);
    return second ? ~d : d;
  endfunction
endpackage

// File: rtl/dacrb_wr_decode.sv
module dacrb_wr_decode
  import dacrb_pkg::*;
#(
  parameter int N    = N_CH,
  parameter int AW   = ADDR_W
) (
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  code_t                wr_data,
  input  logic                 twos,
  output logic [N-1:0]         chan_we,
  output code_t [N-1:0]        chan_wdata,
  output logic                 ctrl0_we,
  output logic                 ctrl1_we,
  output logic                 preset_we
);
  code_t conv;
  logic  pair_sel;

  assign conv      = fmt_code(wr_data, twos);
  assign pair_sel  = (wr_addr >= AW'(A_PAIR0));
  assign ctrl0_we  = wr_en && (wr_addr == AW'(A_CTRL0));
  assign ctrl1_we  = wr_en && (wr_addr == AW'(A_CTRL1));
  assign preset_we = wr_en && (wr_addr == AW'(A_PRESET));

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign chan_we[i] = wr_en && ((wr_addr == AW'(i)) ||
                                  (wr_addr == AW'(A_PAIR0 + i / 2)));
    assign chan_wdata[i] = pair_code(conv, pair_sel && (i % 2 == 1));
  end
endmodule

// File: rtl/dacrb_code_bank.sv
module dacrb_code_bank
  import dacrb_pkg::*;
#(
  parameter int N = N_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  chan_we,
  input  code_t [N-1:0] chan_wdata,
  input  logic          load_n,
  output code_t [N-1:0] in_codes,
  output code_t [N-1:0] out_codes
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_codes[i]  <= '0;
        out_codes[i] <= '0;
      end else begin
        if (chan_we[i]) in_codes[i] <= chan_wdata[i];
        if (!load_n)    out_codes[i] <= in_codes[i];
      end
    end
  end
endmodule

// File: rtl/dacrb_preset.sv
module dacrb_preset
  import dacrb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  preset_we,
  input  code_t wr_data,
  input  logic  preset_n,
  output logic  preset_active,
  output code_t preset_value
);
  logic [1:0] sync_q;
  logic       written_q;
  code_t      preset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      written_q <= 1'b0;
      preset_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], preset_n};
      if (preset_we) begin
        preset_q  <= wr_data;
        written_q <= 1'b1;
      end
    end
  end

  assign preset_active = !sync_q[1];
  assign preset_value  = written_q ? preset_q : '0;
endmodule

// File: rtl/dac_regbank_ctrl.sv
module dac_regbank_ctrl
  import dacrb_pkg::*;
#(
  parameter int N_CHAN = N_CH,
  parameter int CW     = CODE_W,
  parameter int AW     = ADDR_W,
  localparam int NP    = N_CHAN / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic               load_n,
  input  logic               preset_n,
  output logic [N_CHAN*CW-1:0] dac_code,
  output logic [N_CHAN-1:0]  ch_pd,
  output logic [NP-1:0]      pair_fast,
  output logic               ref_internal,
  output logic               ref_high,
  output logic               dout_en
);
  logic [N_CHAN-1:0]  chan_we;
  code_t [N_CHAN-1:0] chan_wdata;
  code_t [N_CHAN-1:0] in_codes;
  code_t [N_CHAN-1:0] out_codes;
  logic               ctrl0_we, ctrl1_we, preset_we;
  logic               preset_active;
  code_t              preset_value;
  ctrl0_t             ctrl0_q;
  logic [2*NP-1:0]    ctrl1_q;
  logic               full_pd;
  logic [12:0]        ctrl_state;

  dacrb_wr_decode #(.N(N_CHAN), .AW(AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .twos(ctrl0_q.twos), .chan_we(chan_we), .chan_wdata(chan_wdata),
    .ctrl0_we(ctrl0_we), .ctrl1_we(ctrl1_we), .preset_we(preset_we)
  );

  dacrb_code_bank #(.N(N_CHAN)) u_bank (
    .clk(clk), .rst_n(rst_n), .chan_we(chan_we), .chan_wdata(chan_wdata),
    .load_n(load_n), .in_codes(in_codes), .out_codes(out_codes)
  );

  dacrb_preset u_preset (
    .clk(clk), .rst_n(rst_n), .preset_we(preset_we), .wr_data(wr_data),
    .preset_n(preset_n), .preset_active(preset_active),
    .preset_value(preset_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
    end else begin
      if (ctrl0_we) ctrl0_q <= ctrl0_t'(wr_data[4:0]);
      if (ctrl1_we) ctrl1_q <= wr_data[2*NP-1:0];
    end
  end

  assign full_pd      = ctrl0_q.full_pd;
  assign dout_en      = ctrl0_q.dout_en;
  assign ref_internal = ctrl0_q.ref_int;
  assign ref_high     = ctrl0_q.ref_hi;
  assign pair_fast    = ctrl1_q[NP-1:0];
  assign ctrl_state   = {ctrl0_q, ctrl1_q};

  for (genvar i = 0; i < N_CHAN; i++) begin : g_out
    assign dac_code[i*CW +: CW] = preset_active ? preset_value : out_codes[i];
    assign ch_pd[i] = full_pd | ctrl1_q[NP + i / 2];
  end
endmodule

// File: rtl/dacrb_checker.sv
module dacrb_checker
  import dacrb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               load_n,
  input logic               preset_active,
  input code_t              preset_value,
  input logic [N_CH*CODE_W-1:0] dac_code,
  input logic [N_CH-1:0]    ch_pd,
  input logic               full_pd,
  input code_t [N_CH-1:0]   in_codes,
  input code_t [N_CH-1:0]   out_codes,
  input logic [12:0]        ctrl_state
);
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(out_codes)); // R2

  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> out_codes == $past(in_codes)); // R3

  AST_FULL_PD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    full_pd |-> (ch_pd == '1)); // R6

  AST_PRESET_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    preset_active |-> (dac_code == {N_CH{preset_value}})); // R7

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(A_PAIR0)) |=>
      (in_codes[{$past(wr_addr[1:0]), 1'b0}] ==
       ~in_codes[{$past(wr_addr[1:0]), 1'b1}])); // R9

  AST_ADDR11_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(11)) |=>
      ($stable(in_codes) && $stable(ctrl_state) && $stable(preset_value))); // R11
endmodule

bind dac_regbank_ctrl dacrb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .load_n(load_n), .preset_active(preset_active),
  .preset_value(preset_value), .dac_code(dac_code), .ch_pd(ch_pd),
  .full_pd(full_pd), .in_codes(in_codes), .out_codes(out_codes),
  .ctrl_state(ctrl_state)
);

// File: tb/test_dac_regbank_ctrl.sv
module test_dac_regbank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {wr, addr[3:0], data[11:0], ch[2:0], expected[11:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 4'd0,  12'h123, 3'd0, 12'h123},
    {1'b1, 4'd7,  12'hABC, 3'd7, 12'hABC},
    {1'b1, 4'd3,  12'hFFF, 3'd3, 12'hFFF},
    {1'b1, 4'd12, 12'hFFF, 3'd0, 12'hFFF},
    {1'b0, 4'd0,  12'h000, 3'd1, 12'h000},
    {1'b1, 4'd15, 12'h5A5, 3'd6, 12'h5A5},
    {1'b0, 4'd0,  12'h000, 3'd7, 12'hA5A},
    {1'b1, 4'd13, 12'h0F0, 3'd2, 12'h0F0},
    {1'b0, 4'd0,  12'h000, 3'd3, 12'hF0F}
  };

  logic        clk = 0, rst_n = 0, wr_en = 0, load_n = 0, preset_n = 1;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [95:0] dac_code;
  logic [7:0]  ch_pd;
  logic [3:0]  pair_fast;
  logic        ref_internal, ref_high, dout_en;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_regbank_ctrl i_dac_regbank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_n(load_n), .preset_n(preset_n),
    .dac_code(dac_code), .ch_pd(ch_pd), .pair_fast(pair_fast),
    .ref_internal(ref_internal), .ref_high(ref_high), .dout_en(dout_en)
  );

  function automatic logic [11:0] ch(int i);
    return dac_code[i*12 +: 12];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [11:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_preset(logic v);
    @(negedge clk); preset_n = v;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 codes", {31'd0, |dac_code}, 0);
    check("R1 ctrl", {ch_pd, pair_fast, ref_internal, ref_high, dout_en}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][31]) begin
        do_write(VEC[k][30:27], VEC[k][26:15]);
        @(negedge clk);
      end
      check(VEC[k][30:27] >= 12 ? "R9 pair" : "R3 load", ch(int'(VEC[k][14:12])),
            VEC[k][11:0]);
    end

    // R8: preset never written gives zero scale
    set_preset(0);
    check("R8 zero ch0", ch(0), 0);
    check("R8 zero ch7", ch(7), 0);
    set_preset(1);
    check("R7 release", ch(6), 12'h5A5);

    // R7: written preset broadcast
    do_write(4'd10, 12'h456);
    set_preset(0);
    for (int i = 0; i < 8; i++) check("R7 broadcast", ch(i), 12'h456);
    set_preset(1);
    check("R7 release held", ch(3), 12'hF0F);

    // R2 hold with load high, R3 follow when released low
    @(negedge clk); load_n = 1;
    do_write(4'd1, 12'h777);
    @(negedge clk);
    check("R2 hold", ch(1), 12'h000);
    load_n = 0;
    @(negedge clk);
    check("R3 load", ch(1), 12'h777);

    // R4 global control bits
    do_write(4'd8, 12'h01E);
    check("R4 bits", {ch_pd, dout_en, ref_internal, ref_high}, {8'hFF, 3'b111});
    do_write(4'd8, 12'h00C);
    check("R4 bits", {ch_pd, dout_en, ref_internal, ref_high}, {8'h00, 3'b110});

    // R5 pair control
    do_write(4'd9, 12'h0A5);
    check("R5 pd", ch_pd, 8'hCC);
    check("R5 fast", pair_fast, 4'h5);

    // R6 full power-down overrides and keeps pair flags
    do_write(4'd8, 12'h01C);
    check("R6 all", ch_pd, 8'hFF);
    do_write(4'd8, 12'h00C);
    check("R6 kept", ch_pd, 8'hCC);

    // R10 signed input
    do_write(4'd8, 12'h001);
    do_write(4'd4, 12'h7FF);
    @(negedge clk);
    check("R10 single", ch(4), 12'hFFF);
    do_write(4'd14, 12'h000);
    @(negedge clk);
    check("R10 pair first", ch(4), 12'h800);
    check("R10 pair second", ch(5), 12'h7FF);
    do_write(4'd10, 12'h123);
    set_preset(0);
    check("R10 preset raw", ch(0), 12'h123);
    set_preset(1);
    do_write(4'd8, 12'h000);

    // R11 address 11 ignored
    do_write(4'd11, 12'hFFF);
    @(negedge clk);
    check("R11 ctrl", {ch_pd, pair_fast, dout_en, ref_internal, ref_high},
          {8'hCC, 4'h5, 3'b000});
    check("R11 code", ch(4), 12'h800);
    set_preset(0);
    check("R11 preset", ch(2), 12'h123);
    set_preset(1);

    // R12 asynchronous reset mid-run
    @(negedge clk);
    #1 rst_n = 0;
    #1;
    check("R12 codes", {31'd0, |dac_code}, 0);
    check("R12 ctrl", {ch_pd, pair_fast}, 0);
    @(negedge clk); rst_n = 1;
    set_preset(0);
    check("R12 preset flag", ch(5), 0);
    set_preset(1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule